// File: doc/BRIEF.md
# Inter-Processor Doorbell Unit

The doorbell unit lets any processor in a cluster raise software interrupts on a chosen group of processors. One shared trigger register is written with a target-processor bitmap and a doorbell number. Each targeted processor gets that bit set in its own pending-doorbell register.

Each processor sees a banked pair of registers, selected by the processor-ID input on the register bus. The first holds pending doorbells, and the processor clears them by writing zeros. The second is an enable mask. For each processor, the unit drives a request line that is high while any pending doorbell is also enabled. That line feeds input 0 of the interrupt distributor.

Register writes take effect on the clock edge at which `bus_wr` is sampled high. Reads are combinational on the bus address and processor ID.

Top module: `doorbell_unit`

## Requirements
- R1: After reset every pending register and every mask register reads zero, and every request output is low.
- R2: A write to offset 0x4 sets, in the pending register of each processor whose bit is set in data bits [15:8] (bit 8 + n for processor n), the bit whose index is given by data bits [4:0]. The pending registers of processors not targeted are unchanged.
- R3: Target bits in [15:8] that name a processor index at or above NUM_CPUS have no effect on any pending register.
- R4: A write to offset 0x8 replaces the pending register of the processor named by `bus_cpu_id` with its bitwise AND with the write data. The pending registers of all other processors are unchanged.
- R5: Writing 0 to offset 0x8 clears every pending bit. Writing 0xFFFFFF00 clears bits [7:0] and keeps bits [31:8].
- R6: Offset 0xC is the mask register of the processor named by `bus_cpu_id`. It reads back the value last written there, and each processor's mask is independent.
- R7: `dbell_req[n]` is high exactly when processor n's pending register AND its mask register is nonzero.
- R8: Reads of offset 0x8 and 0xC return the banked register of the processor named by `bus_cpu_id`. Reads of any other offset, including 0x4, return zero.
- R9: Writes to offsets other than 0x4, 0x8 and 0xC change no register and no request output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_cpu_id | input | CPU_W | Processor issuing the access; selects the banked registers |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data for `bus_addr` and `bus_cpu_id` |
| dbell_req | output | NUM_CPUS | Per-processor doorbell request to distributor input 0 |

## Verification
The trigger register is swept through all 256 target bitmaps. Each write uses a doorbell number and issuing processor derived from the bitmap, so fan-out to subsets, ignored upper targets and independence from the writer's ID are all separated. Pending bits accumulate between periodic full clears, which shows that triggers OR into existing state rather than overwrite it. Mixed-bit AND patterns and the 0xFFFFFF00 clear separate a bitwise AND from a full clear. They also show that one processor's clear leaves the other banks untouched. The request line is checked against masks that do and do not overlap the pending bit, and writes to unused offsets are checked for no effect.

// File: rtl/doorbell_unit.sv
module doorbell_unit #(
  parameter int NUM_CPUS = 4,
  parameter int DATA_W   = 32,
  parameter int ADDR_W   = 4,
  localparam int CPU_W   = (NUM_CPUS > 1) ? $clog2(NUM_CPUS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CPU_W-1:0]    bus_cpu_id,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CPUS-1:0] dbell_req
);
  localparam int NUM_W     = $clog2(DATA_W);
  localparam int OFF_TRIG  = 4;
  localparam int OFF_CAUSE = 8;
  localparam int OFF_MASK  = 12;
  localparam int MAP_LSB   = 8;

  logic [DATA_W-1:0] cause_q [NUM_CPUS];
  logic [DATA_W-1:0] mask_q  [NUM_CPUS];

  wire trig_we  = bus_wr && (bus_addr == ADDR_W'(OFF_TRIG));
  wire cause_we = bus_wr && (bus_addr == ADDR_W'(OFF_CAUSE));
  wire mask_we  = bus_wr && (bus_addr == ADDR_W'(OFF_MASK));
  wire [DATA_W-1:0] bell_bit = DATA_W'(1) << bus_wdata[NUM_W-1:0];

  for (genvar c = 0; c < NUM_CPUS; c++) begin : g_cpu
    wire own  = (bus_cpu_id == CPU_W'(c));
    wire hit  = trig_we && bus_wdata[MAP_LSB+c];
    wire [DATA_W-1:0] keep = (cause_we && own) ? bus_wdata : '1;
    wire [DATA_W-1:0] set  = hit ? bell_bit : '0;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cause_q[c] <= '0;
        mask_q[c]  <= '0;
      end else begin
        cause_q[c] <= (cause_q[c] & keep) | set;
        if (mask_we && own) mask_q[c] <= bus_wdata;
      end
    end

    assign dbell_req[c] = |(cause_q[c] & mask_q[c]);

    p_trig_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
      trig_we && bus_wdata[MAP_LSB+c] |=> cause_q[c][$past(bus_wdata[NUM_W-1:0])]);

    p_no_set_without_trig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_we |=> (cause_q[c] & ~$past(cause_q[c])) == '0);

    p_other_bank_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !trig_we && !(cause_we && bus_cpu_id == CPU_W'(c)) |=> $stable(cause_q[c]));

    p_mask_write_r6: assert property (@(posedge clk) disable iff (!rst_n)
      mask_we && bus_cpu_id == CPU_W'(c) |=> mask_q[c] == $past(bus_wdata));

    p_req_needs_mask_r7: assert property (@(posedge clk) disable iff (!rst_n)
      dbell_req[c] |-> (mask_q[c] != '0) && (cause_q[c] != '0));
  end

  always_comb begin
    bus_rdata = '0;
    for (int c = 0; c < NUM_CPUS; c++) begin
      if (bus_cpu_id == CPU_W'(c)) begin
        if (bus_addr == ADDR_W'(OFF_CAUSE)) bus_rdata = cause_q[c];
        if (bus_addr == ADDR_W'(OFF_MASK))  bus_rdata = mask_q[c];
      end
    end
  end

  p_rdata_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    bus_addr != ADDR_W'(OFF_CAUSE) && bus_addr != ADDR_W'(OFF_MASK) |-> bus_rdata == '0);
endmodule

// File: tb/doorbell_unit_tb.sv
module doorbell_unit_tb_top;
  localparam int N = 4;
  localparam int W = 32;

  logic clk = 0;
  logic rst_n = 0;
  logic [1:0] bus_cpu_id = 0;
  logic bus_wr = 0;
  logic [3:0] bus_addr = 0;
  logic [W-1:0] bus_wdata = 0;
  logic [W-1:0] bus_rdata;
  logic [N-1:0] dbell_req;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [W-1:0] exp_cause [N];
  logic [W-1:0] exp_mask  [N];

  always #5 clk = ~clk;

  doorbell_unit #(.NUM_CPUS(N), .DATA_W(W), .ADDR_W(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_cpu_id(bus_cpu_id), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .dbell_req(dbell_req));

  task automatic wr(input int id, input int off, input logic [W-1:0] d);
    @(negedge clk);
    bus_cpu_id = id[1:0]; bus_addr = off[3:0]; bus_wdata = d; bus_wr = 1;
    @(negedge clk);
    bus_wr = 0;
  endtask

  task automatic chk_rd(input int id, input int off, input logic [W-1:0] e, input string req);
    bus_cpu_id = id[1:0]; bus_addr = off[3:0];
    #1;
    checks++;
    if (bus_rdata !== e) begin
      fails++;
      $display("FAIL %s cpu%0d off 0x%0h: got 0x%08h expected 0x%08h", req, id, off, bus_rdata, e);
    end
  endtask

  task automatic chk_req(input string req);
    logic [N-1:0] e;
    for (int c = 0; c < N; c++) e[c] = |(exp_cause[c] & exp_mask[c]);
    #1;
    checks++;
    if (dbell_req !== e) begin
      fails++;
      $display("FAIL %s dbell_req: got %b expected %b", req, dbell_req, e);
    end
  endtask

  task automatic chk_all(input string req);
    for (int c = 0; c < N; c++) begin
      chk_rd(c, 8, exp_cause[c], req);
      chk_rd(c, 12, exp_mask[c], req);
    end
    chk_req(req);
  endtask

  task automatic trig(input int id, input logic [7:0] map, input int num);
    wr(id, 4, {16'h0, map, 3'b0, num[4:0]});
    for (int c = 0; c < N; c++)
      if (map[c]) exp_cause[c] = exp_cause[c] | (32'h1 << num);
  endtask

  task automatic clr(input int id, input logic [W-1:0] d);
    wr(id, 8, d);
    exp_cause[id] = exp_cause[id] & d;
  endtask

  task automatic setmask(input int id, input logic [W-1:0] d);
    wr(id, 12, d);
    exp_mask[id] = d;
  endtask

  initial begin
    for (int c = 0; c < N; c++) begin exp_cause[c] = 0; exp_mask[c] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state, R8 unused offsets
    chk_all("R1");
    chk_rd(0, 4, 0, "R8");
    chk_rd(1, 0, 0, "R8");

    // R2/R3 sweep of all target bitmaps, R5 periodic full clears
    for (int bm = 0; bm < 256; bm++) begin
      trig(bm % N, bm[7:0], bm % 32);
      for (int c = 0; c < N; c++) chk_rd(c, 8, exp_cause[c], "R2_R3");
      if (bm % 32 == 31) begin
        for (int c = 0; c < N; c++) clr(c, 0);
        for (int c = 0; c < N; c++) chk_rd(c, 8, 0, "R5");
      end
    end
    // R3 only unimplemented targets
    trig(0, 8'hF0, 3);
    for (int c = 0; c < N; c++) chk_rd(c, 8, 0, "R3");

    // R4 bitwise AND, banked
    for (int n = 0; n < 32; n++) trig(2, 8'h03, n);
    clr(1, 32'h0F0F_00F0);
    chk_rd(1, 8, 32'h0F0F_00F0, "R4");
    chk_rd(0, 8, 32'hFFFF_FFFF, "R4");
    // R5 low-byte clear keeps upper bits
    clr(1, 32'hFFFF_FF00);
    chk_rd(1, 8, 32'h0F0F_0000, "R5");
    clr(0, 32'hFFFF_FF00);
    chk_rd(0, 8, 32'hFFFF_FF00, "R5");
    clr(0, 0); clr(1, 0);
    chk_all("R5");

    // R6 banked masks
    for (int c = 0; c < N; c++) setmask(c, 32'h1111_1111 * (c + 1));
    chk_all("R6");
    for (int c = 0; c < N; c++) setmask(c, 0);

    // R7 request from overlap of pending and mask
    setmask(2, 32'h20);
    trig(3, 8'h04, 4);
    chk_req("R7");
    trig(3, 8'h04, 5);
    chk_req("R7");
    setmask(2, 0);
    chk_req("R7");
    setmask(2, 32'hFFFF_FFFF);
    clr(2, 32'hFFFF_FFDF);
    chk_req("R7");
    setmask(3, 32'h8000_0000);
    trig(0, 8'h08, 31);
    chk_all("R7");

    // R9 writes to unused offsets
    for (int off = 0; off < 16; off++)
      if (off != 4 && off != 8 && off != 12) wr(off % N, off, 32'hFFFF_FFFF);
    chk_all("R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule